// File: doc/BRIEF.md
# Reconfigurable Pipelined-Converter Digital Correction

This block is the digital back end of a pipelined analog-to-digital converter built from 1.5-bit stages. Each clock it receives a redundant two-bit decision (00, 01 or 10) from each of nine identical stage lanes, plus one bit from a closing comparator. The lanes belong to different samples at any moment, because stage k decides one clock after stage k-1. The block delays every lane so that all decisions of one sample meet. It then sums them with one bit of overlap between neighbours, which absorbs comparator offsets inside the redundancy band. The result is a binary word of 6 to 10 bits, together with an out-of-range flag.

The resolution N is chosen at run time. Stages 1 to N-1 take part and the comparator corrects the last of them. The comparator bit is expected N-1 clocks after stage 1's decision for the same sample. Results leave on a valid strobe. The converter behind the block cannot stall, so there is no ready signal on either side. The sink must take each word in the single cycle that `out_valid` is high. Unclaimed words are not stored.

Top module: `pipe_adc_corrector`

## Requirements
- R1: Latency and alignment. A sample begins with `in_valid` high at clock edge e, where lane 0 (stage 1) is captured. Lane i is taken at edge e+i. The comparator bit is taken at edge e+N-1. The corrected word is visible with `out_valid` high just after edge e+N-1.
- R2: The word equals the comparator bit plus the sum, for i = 0..N-2, of lane i's code times 2^(N-2-i).
- R3: When every enabled lane reads 10 and the comparator reads 1, `out_ovf` is high and all N result bits are ones.
- R4: When every enabled lane reads 00 and the comparator reads 0, `out_ovf` is high and the word is zero. In every other case `out_ovf` is low.
- R5: `res_sel` values below 6 act as 6 and values above 10 act as 10. Lanes N-1 and above have no effect on the word or on `code_err`.
- R6: A change of the effective resolution at edge c discards every sample that started at or before c. `out_valid` stays low until a sample started after c completes.
- R7: Code 11 on an enabled lane is summed as 10. It sets `code_err` after that edge, and `code_err` then stays high until reset. Code 11 on a disabled lane is ignored.
- R8: With `left_just` low at the output edge, the word is right-aligned and `out_word` bits N and above are zero.
- R9: With `left_just` high at the output edge, the word is shifted up by 10-N, and the low 10-N bits are zero.
- R10: During reset and before the first edge after it, `out_valid`, `out_word`, `out_ovf` and `code_err` are all zero.
- R11: A sample started with `in_valid` low produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_sel | input | 4 | Requested resolution in bits (clamped to 6..10) |
| left_just | input | 1 | 1 puts the word at the top of `out_word` |
| in_valid | input | 1 | Marks a new sample on lane 0 this cycle |
| stg_code | input | 18 | Lane i's two-bit decision at bits [2i+1:2i] |
| cmp_bit | input | 1 | Closing comparator decision |
| out_valid | output | 1 | A corrected word is present this cycle |
| out_word | output | 10 | Corrected result |
| out_ovf | output | 1 | Input was outside the convertible range |
| code_err | output | 1 | Sticky flag for an illegal 11 code |

## Verification
A lane delay tap that is off by one shifts a neighbouring sample's decision into the sum. This corrupts the first word after the pipeline fills, so the fault is visible within N cycles of any valid input. A wrong valid-pipe tap or a missed flush shows as `out_valid` high on a discarded sample, or low on a real one, in the first N cycles after a resolution change. Faults in the weighting, clamping, justification or overflow decode show on the next word that reaches the affected bit or extreme code. Directed all-high and all-low samples are mixed into the random stream so that such faults appear early.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  typedef logic [1:0] code_t;

  localparam code_t CODE_LO  = 2'b00;
  localparam code_t CODE_MID = 2'b01;
  localparam code_t CODE_HI  = 2'b10;
  localparam code_t CODE_BAD = 2'b11;
endpackage

// File: rtl/adc_stage_align.sv
module adc_stage_align #(
  parameter int NSTG = 9,
  localparam int RSW = $clog2(NSTG + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NSTG-1:0] stg_code,
  input  logic [RSW-1:0]    res_q,
  output logic [2*NSTG-1:0] aln_code
);
  import adc_corr_pkg::*;

  // Lane i (stage i+1) waits res-(i+1) edges; the deepest need is NSTG-i.
  for (genvar i = 0; i < NSTG; i++) begin : g_lane
    localparam int D = NSTG - i;
    code_t raw, fixed, tap;
    code_t sr [D];

    assign raw   = stg_code[2*i +: 2];
    assign fixed = (raw == CODE_BAD) ? CODE_HI : raw;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int j = 0; j < D; j++) sr[j] <= CODE_LO;
      end else begin
        sr[0] <= fixed;
        for (int j = 1; j < D; j++) sr[j] <= sr[j-1];
      end
    end

    always_comb begin
      int t;
      t   = int'(res_q) - (i + 1);
      tap = CODE_LO;
      if (t >= 1 && t <= D) tap = sr[t-1];
    end

    assign aln_code[2*i +: 2] = tap;

    // R7: an illegal code never survives into the summing stage
    a_r7_clean_lane: assert property (@(posedge clk) disable iff (!rst_n)
      tap != CODE_BAD);
  end
endmodule

// File: rtl/adc_res_ctrl.sv
module adc_res_ctrl #(
  parameter int NSTG = 9,
  parameter int RMIN = 6,
  localparam int RMAX = NSTG + 1,
  localparam int RSW  = $clog2(NSTG + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RSW-1:0]    res_sel,
  input  logic              in_valid,
  input  logic [2*NSTG-1:0] stg_code,
  output logic [RSW-1:0]    res_q,
  output logic              chg,
  output logic              aln_v,
  output logic              code_err
);
  import adc_corr_pkg::*;

  logic [RSW-1:0]  rc;
  logic [NSTG-1:0] vsh;
  logic            bad_hit;

  always_comb begin
    if (int'(res_sel) < RMIN)      rc = RSW'(RMIN);
    else if (int'(res_sel) > RMAX) rc = RSW'(RMAX);
    else                           rc = res_sel;
  end

  assign chg = (rc != res_q);

  always_comb begin
    bad_hit = 1'b0;
    for (int i = 0; i < NSTG; i++)
      if (i < int'(res_q) - 1 && stg_code[2*i +: 2] == CODE_BAD) bad_hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q    <= RSW'(RMAX);
      vsh      <= '0;
      code_err <= 1'b0;
    end else begin
      res_q <= rc;
      vsh   <= chg ? '0 : {vsh[NSTG-2:0], in_valid};
      if (bad_hit) code_err <= 1'b1;
    end
  end

  // vsh[j] holds the start flag from j+1 edges back; the aligned sample is N-1 back.
  always_comb begin
    int k;
    k     = int'(res_q) - 2;
    aln_v = 1'b0;
    if (k >= 0 && k < NSTG) aln_v = vsh[k];
  end

  // R7: error flag never drops once raised
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(code_err) |-> code_err);

  // R5: the working resolution always sits inside the legal band
  a_r5_res_band: assert property (@(posedge clk) disable iff (!rst_n)
    int'(res_q) >= RMIN && int'(res_q) <= RMAX);
endmodule

// File: rtl/adc_overlap_sum.sv
module adc_overlap_sum #(
  parameter int NSTG = 9,
  localparam int W   = NSTG + 1,
  localparam int RSW = $clog2(NSTG + 2)
) (
  input  logic [2*NSTG-1:0] aln_code,
  input  logic              cmp_bit,
  input  logic [RSW-1:0]    res_q,
  input  logic              left_just,
  output logic [W-1:0]      word,
  output logic              ovf
);
  import adc_corr_pkg::*;

  logic [W-1:0] acc;
  logic         all_hi, all_lo;

  always_comb begin
    acc    = '0;
    all_hi = 1'b1;
    all_lo = 1'b1;
    for (int i = 0; i < NSTG; i++) begin
      if (i < int'(res_q) - 1) begin
        acc    = acc + (W'(aln_code[2*i +: 2]) << (int'(res_q) - 2 - i));
        all_hi = all_hi & (aln_code[2*i +: 2] == CODE_HI);
        all_lo = all_lo & (aln_code[2*i +: 2] == CODE_LO);
      end
    end
    acc  = acc + W'(cmp_bit);
    ovf  = (all_hi & cmp_bit) | (all_lo & ~cmp_bit);
    word = left_just ? (acc << (W - int'(res_q))) : acc;
  end
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
  parameter int NSTG = 9,
  parameter int RMIN = 6,
  localparam int W   = NSTG + 1,
  localparam int RSW = $clog2(NSTG + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RSW-1:0]    res_sel,
  input  logic              left_just,
  input  logic              in_valid,
  input  logic [2*NSTG-1:0] stg_code,
  input  logic              cmp_bit,
  output logic              out_valid,
  output logic [W-1:0]      out_word,
  output logic              out_ovf,
  output logic              code_err
);
  logic [RSW-1:0]    res_q;
  logic              chg, aln_v;
  logic [2*NSTG-1:0] aln_code;
  logic [W-1:0]      sum_word;
  logic              sum_ovf;
  logic [W-1:0]      lo_mask;

  adc_res_ctrl #(.NSTG(NSTG), .RMIN(RMIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .in_valid(in_valid),
    .stg_code(stg_code), .res_q(res_q), .chg(chg), .aln_v(aln_v),
    .code_err(code_err)
  );

  adc_stage_align #(.NSTG(NSTG)) u_align (
    .clk(clk), .rst_n(rst_n), .stg_code(stg_code), .res_q(res_q),
    .aln_code(aln_code)
  );

  adc_overlap_sum #(.NSTG(NSTG)) u_sum (
    .aln_code(aln_code), .cmp_bit(cmp_bit), .res_q(res_q),
    .left_just(left_just), .word(sum_word), .ovf(sum_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= aln_v & ~chg;
      if (aln_v && !chg) begin
        out_word <= sum_word;
        out_ovf  <= sum_ovf;
      end
    end
  end

  assign lo_mask = W'((1 << (W - int'(res_q))) - 1);

  // R6: the edge that takes a new resolution never emits a word
  a_r6_hold_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q != $past(res_q)) |-> !out_valid);

  // R8: right-aligned words keep bits at and above N clear
  a_r8_high_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(left_just)) |-> ((out_word >> res_q) == '0));

  // R9: left-aligned words keep the bottom W-N bits clear
  a_r9_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(left_just)) |-> ((out_word & lo_mask) == '0));

  // R3 / R4: an out-of-range word is either all ones over N bits or zero
  a_r3_ovf_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_word == '0 || $countones(out_word) == int'(res_q)));
endmodule

// File: tb/sim_pipe_adc_corrector.sv
`timescale 1ns/1ps
module sim_pipe_adc_corrector;
  localparam int NSTG = 9;
  localparam int MAXS = 4096;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [3:0]  res_sel;
  logic        left_just;
  logic        in_valid;
  logic [17:0] stg_code;
  logic        cmp_bit;
  logic        out_valid;
  logic [9:0]  out_word;
  logic        out_ovf;
  logic        code_err;

  pipe_adc_corrector u0 (
    .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .left_just(left_just),
    .in_valid(in_valid), .stg_code(stg_code), .cmp_bit(cmp_bit),
    .out_valid(out_valid), .out_word(out_word), .out_ovf(out_ovf),
    .code_err(code_err)
  );

  logic [1:0] s_code [MAXS][NSTG];
  logic       s_cmp  [MAXS];
  logic       s_v    [MAXS];

  int checks = 0, errors = 0;
  int g = 0, n_q = 10, flush_g = -1;
  bit err_exp = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, g);
    end
  endtask

  function automatic int clampn(int r);
    if (r < 6)  return 6;
    if (r > 10) return 10;
    return r;
  endfunction

  task automatic gen(int s, int mode);
    int r;
    r = int'($urandom % 8);
    s_v[s] = ($urandom % 8) != 0;
    for (int i = 0; i < NSTG; i++) begin
      if (mode == 2 || (mode == 1 && i >= 5)) s_code[s][i] = 2'($urandom % 4);
      else                                    s_code[s][i] = 2'($urandom % 3);
    end
    s_cmp[s] = 1'($urandom % 2);
    if (r == 0) begin
      for (int i = 0; i < 5; i++) s_code[s][i] = 2'b10;
      if (mode == 0) for (int i = 5; i < NSTG; i++) s_code[s][i] = 2'b10;
      s_cmp[s] = 1'b1;
    end else if (r == 1) begin
      for (int i = 0; i < 5; i++) s_code[s][i] = 2'b00;
      if (mode == 0) for (int i = 5; i < NSTG; i++) s_code[s][i] = 2'b00;
      s_cmp[s] = 1'b0;
    end
  endtask

  function automatic int lane_val(int s, int i);
    int c;
    c = int'(s_code[s][i]);
    return (c == 3) ? 2 : c;
  endfunction

  function automatic int exp_word(int s, int n, bit lj);
    int acc;
    acc = int'(s_cmp[s]);
    for (int i = 0; i < n - 1; i++) acc += lane_val(s, i) << (n - 2 - i);
    return lj ? (acc << (10 - n)) : acc;
  endfunction

  function automatic bit exp_ovf(int s, int n);
    bit hi, lo;
    hi = s_cmp[s];
    lo = !s_cmp[s];
    for (int i = 0; i < n - 1; i++) begin
      hi &= (lane_val(s, i) == 2);
      lo &= (lane_val(s, i) == 0);
    end
    return hi | lo;
  endfunction

  task automatic run_seg(int sel, int mode, int cycles);
    int n, s, ew;
    bit pend, lj, ev, eo;
    n = clampn(sel);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      gen(g, mode);
      res_sel   = 4'(sel);
      lj        = 1'($urandom % 2);
      left_just = lj;
      in_valid  = s_v[g];
      for (int i = 0; i < NSTG; i++)
        stg_code[2*i +: 2] = (g - i >= 0) ? s_code[g-i][i] : 2'b00;
      cmp_bit = (g - n + 1 >= 0) ? s_cmp[g-n+1] : 1'b0;
      pend = 1'b0;
      for (int i = 0; i < n_q - 1; i++)
        if (stg_code[2*i +: 2] == 2'b11) pend = 1'b1;   // R7 enabled-lane rule
      if (n != n_q) flush_g = g;                        // R6 discard point
      @(posedge clk);
      #1;
      n_q = n;
      err_exp |= pend;
      s  = g - (n - 1);
      ev = (s >= 0) && (s > flush_g) && s_v[s];
      chk(out_valid == ev, "R1/R6/R11 out_valid", int'(out_valid), int'(ev));
      if (ev && out_valid) begin
        ew = exp_word(s, n, lj);
        eo = exp_ovf(s, n);
        if (eo && s_cmp[s])
          chk(out_word == 10'(ew), "R3 saturated high word", int'(out_word), ew);
        else if (eo)
          chk(out_word == 10'(ew), "R4 saturated low word", int'(out_word), ew);
        else if (lj)
          chk(out_word == 10'(ew), "R9 left-justified word", int'(out_word), ew);
        else
          chk(out_word == 10'(ew), "R2/R8 corrected word", int'(out_word), ew);
        chk(out_ovf == eo, "R3/R4 overflow flag", int'(out_ovf), int'(eo));
      end
      chk(code_err == err_exp, "R5/R7 sticky error", int'(code_err), int'(err_exp));
      g++;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; res_sel = 4'd10; left_just = 1'b0; in_valid = 1'b0;
    stg_code = '0; cmp_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 reset out_valid", int'(out_valid), 0);
    chk(out_word == '0,    "R10 reset out_word",  int'(out_word), 0);
    chk(out_ovf == 1'b0,   "R10 reset out_ovf",   int'(out_ovf), 0);
    chk(code_err == 1'b0,  "R10 reset code_err",  int'(code_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_seg(8, 0, 250);
    run_seg(6, 0, 250);
    run_seg(10, 0, 250);
    run_seg(7, 0, 250);
    run_seg(3, 0, 250);    // R5 clamp up to 6
    run_seg(9, 0, 250);
    run_seg(15, 0, 250);   // R5 clamp down to 10
    run_seg(6, 1, 250);    // R5/R7 illegal codes only on disabled lanes
    run_seg(9, 2, 250);    // R7 illegal codes on enabled lanes
    chk(err_exp == 1'b1, "R7 injection reached an enabled lane", int'(err_exp), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule